// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a power and lighting controller through its operating modes: reset, standby, a timed startup that brings up the reference and oscillator, a timed low-current soft-start for the boost converter, and normal operation. It reads an active-low reset pin, a power-on-reset flag, a thermal-shutdown flag, and two control register bits. One bit asks the chip to leave standby, and the other asks for the boost converter. From these it drives a mode code and three enables for the analog blocks.

Both timed phases count ticks of a clock prescaler. One phase lasts `TICK_DIV * DELAY_TICKS` system clocks plus one edge, so simulation can use short delays and silicon can use the full 10 ms. The boost register bit is only acted on when startup completes, so register writes made in standby take effect at the end of startup. After that, the boost bit can be cleared and set again while the chip stays in normal mode. Analog supply and temperature sensing are outside the block and arrive as digital flags.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_pin_n` is low or `por_flag` is high, the next clock edge puts the block in reset (`mode_code` = 0), and all three enables are low.
- R2: Outside reset, with `stby_exit` low, the block sits in standby (`mode_code` = 1) with all enables low. `tsd_flag` and `boost_en` have no effect there.
- R3: In standby, `stby_exit` high moves the block to startup (`mode_code` = 2) on the next edge, and `ref_osc_en` goes high.
- R4: Startup leaves on the (TICK_DIV*DELAY_TICKS+1)-th clock edge after the entry edge. With `boost_en` low it goes to normal (`mode_code` = 4) with `boost_full_en` low.
- R5: If `boost_en` is high when startup completes, the block enters boost soft-start (`mode_code` = 3, `boost_soft_en` high). Soft-start lasts the same edge count as startup and then ends in normal with `boost_full_en` high. `boost_en` does nothing before startup completes.
- R6: In normal, `boost_en` low clears `boost_full_en` on the next edge while `mode_code` stays 4.
- R7: In normal with the converter off, `boost_en` high enters soft-start on the next edge. Dropping `boost_en` during soft-start returns to normal with `boost_full_en` low.
- R8: `tsd_flag` high in startup, soft-start or normal forces startup on the next edge, holds it there, and keeps the soft-start and full boost enables low. After the flag clears, startup completes on the (TICK_DIV*DELAY_TICKS+1)-th edge that samples the flag low.
- R9: `stby_exit` low in startup, soft-start or normal returns the block to standby on the next edge, with all enables low.
- R10: The delay count restarts on every entry into a timed mode, so a startup interrupted and entered again runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Active-low reset pin |
| por_flag | input | 1 | Power-on-reset active |
| tsd_flag | input | 1 | Thermal shutdown event active |
| stby_exit | input | 1 | Register bit requesting exit from standby |
| boost_en | input | 1 | Register bit requesting the boost converter |
| mode_code | output | 3 | 0 reset, 1 standby, 2 startup, 3 boost soft-start, 4 normal |
| ref_osc_en | output | 1 | Reference and oscillator enable |
| boost_soft_en | output | 1 | Low-current boost soft-start enable |
| boost_full_en | output | 1 | Full boost converter enable |

## Verification
The bench checks where each timed phase ends, sampling one cycle before and on the cycle of the exit edge. A prescaler or delay compare that is off by one would make the exit early or late by a cycle. A thermal event that is held far longer than one delay period must not release startup, and after it clears the full period must run again. A counter that kept running through the event would let the block leave early. The bench also sets the boost bit in standby and expects no soft-start until startup completes. It cycles the boost bit in normal and drops it during soft-start, where a converter flag left set would show up as a full enable that stays high. Interrupting startup and entering it again targets a timer that fails to restart on entry.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int TICK_DIV    = 4,
  parameter int DELAY_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       por_flag,
  input  logic       tsd_flag,
  input  logic       stby_exit,
  input  logic       boost_en,
  output logic [2:0] mode_code,
  output logic       ref_osc_en,
  output logic       boost_soft_en,
  output logic       boost_full_en
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int DW = $clog2(DELAY_TICKS + 1);

  typedef enum logic [2:0] {
    M_RESET   = 3'd0,
    M_STANDBY = 3'd1,
    M_STARTUP = 3'd2,
    M_SOFT    = 3'd3,
    M_NORMAL  = 3'd4
  } mode_t;

  mode_t           state, nxt;
  logic [PW-1:0]   pre;
  logic [DW-1:0]   dly;
  logic            boost_run;

  wire hold_rst = !rst_pin_n || por_flag;
  wire active   = (state == M_STARTUP) || (state == M_SOFT) || (state == M_NORMAL);
  wire timed    = (state == M_STARTUP) || (state == M_SOFT);
  wire tick     = (pre == PW'(TICK_DIV - 1));
  wire done     = (dly == DW'(DELAY_TICKS));

  always_comb begin
    nxt = state;
    if (hold_rst)                      nxt = M_RESET;
    else if (state == M_RESET)         nxt = M_STANDBY;
    else if (!stby_exit)               nxt = M_STANDBY;
    else if (state == M_STANDBY)       nxt = M_STARTUP;
    else if (tsd_flag)                 nxt = M_STARTUP;
    else begin
      case (state)
        M_STARTUP: if (done) nxt = boost_en ? M_SOFT : M_NORMAL;
        M_SOFT:    if (!boost_en || done) nxt = M_NORMAL;
        M_NORMAL:  if (boost_en && !boost_run) nxt = M_SOFT;
        default:   nxt = M_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk) state <= nxt;

  wire restart = (nxt != state) || hold_rst || (nxt == M_STARTUP && tsd_flag);

  always_ff @(posedge clk) begin
    if (restart) begin
      pre <= '0;
      dly <= '0;
    end else if (timed) begin
      if (tick) begin
        pre <= '0;
        if (!done) dly <= dly + DW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hold_rst || nxt != M_NORMAL)
      boost_run <= 1'b0;
    else if (state == M_SOFT)
      boost_run <= boost_en;
    else if (!boost_en)
      boost_run <= 1'b0;
  end

  assign mode_code     = state;
  assign ref_osc_en    = active;
  assign boost_soft_en = (state == M_SOFT);
  assign boost_full_en = boost_run;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_pin_n,
  input logic       por_flag,
  input logic       tsd_flag,
  input logic       stby_exit,
  input logic       boost_en,
  input logic [2:0] mode_code,
  input logic       ref_osc_en,
  input logic       boost_soft_en,
  input logic       boost_full_en
);

  assert_por_reset_R1: assert property (@(posedge clk) disable iff (!rst_pin_n)
    por_flag |=> (mode_code == 3'd0 && !ref_osc_en && !boost_full_en));

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (mode_code == 3'd1) |-> (!ref_osc_en && !boost_soft_en && !boost_full_en));

  assert_enter_startup_R3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!por_flag && stby_exit && mode_code == 3'd1) |=> (mode_code == 3'd2 && ref_osc_en));

  assert_soft_needs_ref_R5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    boost_soft_en |-> (ref_osc_en && !boost_full_en));

  assert_boost_off_R6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !boost_en |=> !boost_full_en);

  assert_thermal_startup_R8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!por_flag && stby_exit && tsd_flag && mode_code >= 3'd2)
      |=> (mode_code == 3'd2 && !boost_soft_en && !boost_full_en));

  assert_back_to_standby_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!por_flag && !stby_exit) |=> (mode_code == 3'd1));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (.*);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int TD = 4;
  localparam int NT = 10;
  localparam int P  = TD * NT + 1;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, por_flag = 1'b0, tsd_flag = 1'b0, stby_exit = 1'b0, boost_en = 1'b0;
  logic [2:0] mode_code;
  logic ref_osc_en, boost_soft_en, boost_full_en;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.TICK_DIV(TD), .DELAY_TICKS(NT)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .por_flag(por_flag), .tsd_flag(tsd_flag),
    .stby_exit(stby_exit), .boost_en(boost_en), .mode_code(mode_code),
    .ref_osc_en(ref_osc_en), .boost_soft_en(boost_soft_en), .boost_full_en(boost_full_en));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic look(input string req, input int m, input int r, input int s, input int f);
    chk(req, "mode", mode_code, m);
    chk(req, "ref_osc_en", ref_osc_en, r);
    chk(req, "boost_soft_en", boost_soft_en, s);
    chk(req, "boost_full_en", boost_full_en, f);
  endtask

  task automatic do_reset();
    rst_pin_n = 1'b0; stby_exit = 1'b0; boost_en = 1'b0; tsd_flag = 1'b0; por_flag = 1'b0;
    step(2);
    rst_pin_n = 1'b1;
    step(1);
  endtask

  task automatic to_normal(input string req);
    stby_exit = 1'b1;
    step(1); look(req, 2, 1, 0, 0);
    step(P - 1); look(req, 2, 1, 0, 0);
    step(1); look(req, 4, 1, 0, 0);
  endtask

  task automatic t_reset_standby();
    rst_pin_n = 1'b0;
    step(3); look("R1", 0, 0, 0, 0);
    rst_pin_n = 1'b1;
    step(1); look("R2", 1, 0, 0, 0);
    tsd_flag = 1'b1; boost_en = 1'b1;
    step(6); look("R2", 1, 0, 0, 0);
    tsd_flag = 1'b0; boost_en = 1'b0;
  endtask

  task automatic t_plain_startup();
    do_reset();
    to_normal("R4");
  endtask

  task automatic t_boost_startup();
    do_reset();
    boost_en = 1'b1;
    step(3); look("R5", 1, 0, 0, 0);
    stby_exit = 1'b1;
    step(1); look("R3", 2, 1, 0, 0);
    step(P - 1); look("R5", 2, 1, 0, 0);
    step(1); look("R5", 3, 1, 1, 0);
    step(P - 1); look("R5", 3, 1, 1, 0);
    step(1); look("R5", 4, 1, 0, 1);
  endtask

  task automatic t_boost_toggle();
    boost_en = 1'b0;
    step(1); look("R6", 4, 1, 0, 0);
    step(3); look("R6", 4, 1, 0, 0);
    boost_en = 1'b1;
    step(1); look("R7", 3, 1, 1, 0);
    step(5);
    boost_en = 1'b0;
    step(1); look("R7", 4, 1, 0, 0);
  endtask

  task automatic t_thermal();
    do_reset();
    boost_en = 1'b1;
    stby_exit = 1'b1;
    step(2 * P + 2); look("R8", 4, 1, 0, 1);
    boost_en = 1'b0;
    tsd_flag = 1'b1;
    step(1); look("R8", 2, 1, 0, 0);
    step(2 * P); look("R8", 2, 1, 0, 0);
    tsd_flag = 1'b0;
    step(P - 1); look("R8", 2, 1, 0, 0);
    step(1); look("R8", 4, 1, 0, 0);
  endtask

  task automatic t_restart();
    do_reset();
    stby_exit = 1'b1;
    step(P - 5); look("R10", 2, 1, 0, 0);
    stby_exit = 1'b0;
    step(1); look("R9", 1, 0, 0, 0);
    stby_exit = 1'b1;
    step(1); look("R10", 2, 1, 0, 0);
    step(P - 1); look("R10", 2, 1, 0, 0);
    step(1); look("R10", 4, 1, 0, 0);
  endtask

  task automatic t_exit_normal();
    do_reset();
    boost_en = 1'b1;
    stby_exit = 1'b1;
    step(2 * P + 2); look("R9", 4, 1, 0, 1);
    stby_exit = 1'b0;
    step(1); look("R9", 1, 0, 0, 0);
  endtask

  task automatic t_por();
    do_reset();
    to_normal("R4");
    por_flag = 1'b1; stby_exit = 1'b0;
    step(1); look("R1", 0, 0, 0, 0);
    step(3); look("R1", 0, 0, 0, 0);
    por_flag = 1'b0;
    step(1); look("R2", 1, 0, 0, 0);
    stby_exit = 1'b1;
    step(10);
    rst_pin_n = 1'b0;
    step(1); look("R1", 0, 0, 0, 0);
    rst_pin_n = 1'b1;
  endtask

  initial begin
    step(1);
    t_reset_standby();
    t_plain_startup();
    t_boost_startup();
    t_boost_toggle();
    t_thermal();
    t_restart();
    t_exit_normal();
    t_por();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule